// File: doc/BRIEF.md
# Serial Converter Write-Port Receiver

This block is the digital receive side of a three-wire serial write port that feeds a 12-bit voltage-output converter. A host lowers an active-low frame strobe, then presents sixteen data bits, most significant first, each taken on a falling edge of the serial clock. Once the sixteenth falling edge arrives, the frame is committed. The low twelve bits become the converter code. The next two bits up select the power state. The two leading bits carry no meaning.

The serial clock, the frame strobe and the data line are asynchronous to the block. They pass through multi-stage synchronizers on a fast system clock, and edge detectors follow the synchronizers, so all state in the block changes on that one clock. The outputs are the held code, the held power state with a flag for any powered-down state, a one-cycle strobe for each committed frame and a one-cycle strobe for each discarded frame. If the strobe rises before the sixteenth edge, the frame is thrown away and nothing visible changes.

Top module: `sdac_wport`

## Requirements
- R1: After reset, code_o is 0, mode_o is 0 (normal), powered_down_o is 0, and these values hold through any number of incomplete frames until a full frame commits.
- R2: While the frame strobe is low, each falling edge of sclk_i captures sdi_i, most significant bit first. On the sixteenth edge, code_o takes frame bits 11..0, read as straight binary.
- R3: Frame bits 13..12 set mode_o. The encodings are 0 for normal, 1 for power-down with a 5 kOhm pull-down, 2 for power-down with a 100 kOhm pull-down and 3 for power-down with a floating output. powered_down_o is 1 exactly when mode_o is not 0.
- R4: Frame bits 15..14 do not affect any output. Frames that differ only in those bits produce the same code_o and mode_o.
- R5: If the strobe rises after 0 to 15 falling edges, the frame is discarded. code_o and mode_o keep their values, abort_o pulses once and update_o stays low.
- R6: Falling sclk_i edges after the sixteenth in the same low strobe period do nothing. Edges while the strobe is high also do nothing. A new frame starts only on a falling edge of the strobe.
- R7: update_o is high for exactly one cycle per committed frame, and abort_o is high for exactly one cycle per discarded frame. The two are never high together.
- R8: If the sixteenth falling edge and the strobe rise reach the block in the same system-clock cycle, the frame commits and is not counted as aborted.
- R9: A power-down frame still loads its code field. code_o is not forced to zero while powered_down_o is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than the serial clock |
| rst | input | 1 | Synchronous active-high reset |
| sclk_i | input | 1 | Asynchronous serial clock; data taken on its falling edges |
| frame_n_i | input | 1 | Asynchronous active-low frame strobe |
| sdi_i | input | 1 | Asynchronous serial data |
| code_o | output | 12 | Held converter code |
| mode_o | output | 2 | Held power state (0 normal, 1..3 power-down kinds) |
| powered_down_o | output | 1 | High in any power-down state |
| update_o | output | 1 | One-cycle strobe when a frame commits |
| abort_o | output | 1 | One-cycle strobe when a frame is discarded |

## Verification
Committing a frame and discarding it are two separate functions that can fall in the same system-clock cycle. This happens when the final falling clock edge and the rising strobe pass through the matching synchronizers together. The bench provokes the overlap by moving sclk_i low and frame_n_i high at the same instant on the sixteenth bit. It then judges the result at the ports: the new code and mode must appear, the update count must rise by one and the abort count must not change. Sweeps over every abort length from 0 to 15 edges and over all four power states back this up.

// File: rtl/sdac_pkg.sv
package sdac_pkg;

    // Power state held next to the converter code
    typedef enum logic [1:0] {
        PM_ACTIVE   = 2'd0,
        PM_PD_LOW   = 2'd1,
        PM_PD_HIGH  = 2'd2,
        PM_PD_FLOAT = 2'd3
    } pmode_e;

    // Frame receiver state
    typedef enum logic [1:0] {
        FS_IDLE  = 2'd0,
        FS_SHIFT = 2'd1,
        FS_HOLD  = 2'd2
    } fstate_e;

    localparam int MODE_W = 2;

    function automatic pmode_e mode_from_bits(input logic [MODE_W-1:0] b);
        return pmode_e'(b);
    endfunction

    function automatic logic is_powered_down(input pmode_e m);
        return m != PM_ACTIVE;
    endfunction

endpackage

// File: rtl/sdac_sync.sv
module sdac_sync #(
    parameter int              WIDTH   = 1,
    parameter int              STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);
    logic [STAGES-1:0][WIDTH-1:0] chain_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < STAGES; s++) chain_q[s] <= RST_VAL;
        end else begin
            chain_q[0] <= d_i;
            for (int s = 1; s < STAGES; s++) chain_q[s] <= chain_q[s-1];
        end
    end

    assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/sdac_shifter.sv
module sdac_shifter
    import sdac_pkg::*;
#(
    parameter int FRAME_W   = 16,
    parameter int PAYLOAD_W = 14
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 bit_fall_i,
    input  logic                 frm_fall_i,
    input  logic                 frm_rise_i,
    input  logic                 sdi_i,
    output logic                 commit_o,
    output logic                 abort_o,
    output logic [PAYLOAD_W-1:0] word_o
);
    localparam int CNT_W = $clog2(FRAME_W);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(FRAME_W - 1);

    fstate_e              st_q;
    logic [CNT_W-1:0]     cnt_q;
    // Only the payload survives; leading pad bits fall off the top.
    logic [PAYLOAD_W-2:0] sreg_q;

    logic shifting;

    always_comb begin
        shifting = (st_q == FS_SHIFT);
        word_o   = {sreg_q, sdi_i};
        commit_o = shifting && bit_fall_i && (cnt_q == LAST);
        abort_o  = shifting && frm_rise_i && !commit_o;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= FS_IDLE;
            cnt_q  <= '0;
            sreg_q <= '0;
        end else if (frm_fall_i) begin
            st_q   <= FS_SHIFT;
            cnt_q  <= '0;
            sreg_q <= '0;
        end else if (commit_o) begin
            st_q   <= frm_rise_i ? FS_IDLE : FS_HOLD;
            cnt_q  <= '0;
            sreg_q <= '0;
        end else if (frm_rise_i) begin
            st_q   <= FS_IDLE;
            cnt_q  <= '0;
            sreg_q <= '0;
        end else if (shifting && bit_fall_i) begin
            sreg_q <= word_o[PAYLOAD_W-2:0];
            cnt_q  <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/sdac_regs.sv
module sdac_regs
    import sdac_pkg::*;
#(
    parameter int CODE_W = 12
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     commit_i,
    input  logic                     abort_i,
    input  logic [CODE_W+MODE_W-1:0] word_i,
    output logic [CODE_W-1:0]        code_o,
    output logic [MODE_W-1:0]        mode_o,
    output logic                     powered_down_o,
    output logic                     update_o,
    output logic                     abort_o
);
    logic [CODE_W-1:0] code_q;
    pmode_e            mode_q;
    logic              upd_q;
    logic              abt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            code_q <= '0;
            mode_q <= PM_ACTIVE;
            upd_q  <= 1'b0;
            abt_q  <= 1'b0;
        end else begin
            upd_q <= commit_i;
            abt_q <= abort_i;
            if (commit_i) begin
                code_q <= word_i[CODE_W-1:0];
                mode_q <= mode_from_bits(word_i[CODE_W+MODE_W-1:CODE_W]);
            end
        end
    end

    always_comb begin
        code_o         = code_q;
        mode_o         = mode_q;
        powered_down_o = is_powered_down(mode_q);
        update_o       = upd_q;
        abort_o        = abt_q;
    end
endmodule

// File: rtl/sdac_wport.sv
module sdac_wport
    import sdac_pkg::*;
#(
    parameter int CODE_W      = 12,
    parameter int PAD_W       = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sclk_i,
    input  logic              frame_n_i,
    input  logic              sdi_i,
    output logic [CODE_W-1:0] code_o,
    output logic [1:0]        mode_o,
    output logic              powered_down_o,
    output logic              update_o,
    output logic              abort_o
);
    localparam int PAYLOAD_W = CODE_W + MODE_W;
    localparam int FRAME_W   = PAYLOAD_W + PAD_W;

    // Synchronized copies: {data, strobe, clock}; idle strobe and clock high
    logic [2:0] raw_in, sync_q;
    assign raw_in = {sdi_i, frame_n_i, sclk_i};

    sdac_sync #(
        .WIDTH  (3),
        .STAGES (SYNC_STAGES),
        .RST_VAL(3'b011)
    ) u_sync (
        .clk(clk),
        .rst(rst),
        .d_i(raw_in),
        .q_o(sync_q)
    );

    logic sclk_s, frm_s, sdi_s;
    logic sclk_prev_q, frm_prev_q;
    logic sclk_fall, frm_fall, frm_rise;

    assign sclk_s = sync_q[0];
    assign frm_s  = sync_q[1];
    assign sdi_s  = sync_q[2];

    always_ff @(posedge clk) begin
        if (rst) begin
            sclk_prev_q <= 1'b1;
            frm_prev_q  <= 1'b1;
        end else begin
            sclk_prev_q <= sclk_s;
            frm_prev_q  <= frm_s;
        end
    end

    assign sclk_fall = sclk_prev_q & ~sclk_s;
    assign frm_fall  = frm_prev_q & ~frm_s;
    assign frm_rise  = ~frm_prev_q & frm_s;

    logic                 commit, abort;
    logic [PAYLOAD_W-1:0] word;

    sdac_shifter #(
        .FRAME_W  (FRAME_W),
        .PAYLOAD_W(PAYLOAD_W)
    ) u_shift (
        .clk       (clk),
        .rst       (rst),
        .bit_fall_i(sclk_fall),
        .frm_fall_i(frm_fall),
        .frm_rise_i(frm_rise),
        .sdi_i     (sdi_s),
        .commit_o  (commit),
        .abort_o   (abort),
        .word_o    (word)
    );

    sdac_regs #(
        .CODE_W(CODE_W)
    ) u_regs (
        .clk           (clk),
        .rst           (rst),
        .commit_i      (commit),
        .abort_i       (abort),
        .word_i        (word),
        .code_o        (code_o),
        .mode_o        (mode_o),
        .powered_down_o(powered_down_o),
        .update_o      (update_o),
        .abort_o       (abort_o)
    );
endmodule

// File: rtl/sdac_wport_chk.sv
module sdac_wport_chk #(
    parameter int CODE_W = 12
) (
    input logic              clk,
    input logic              rst,
    input logic [CODE_W-1:0] code_o,
    input logic [1:0]        mode_o,
    input logic              update_o,
    input logic              abort_o
);
    assert_code_only_on_update_R2: assert property (@(posedge clk) disable iff (rst)
        !$stable(code_o) |-> update_o);

    assert_mode_only_on_update_R3: assert property (@(posedge clk) disable iff (rst)
        !$stable(mode_o) |-> update_o);

    assert_abort_keeps_state_R5: assert property (@(posedge clk) disable iff (rst)
        abort_o |-> ($stable(code_o) && $stable(mode_o)));

    assert_update_single_R7: assert property (@(posedge clk) disable iff (rst)
        update_o |=> !update_o);

    assert_abort_single_R7: assert property (@(posedge clk) disable iff (rst)
        abort_o |=> !abort_o);

    assert_no_both_R7: assert property (@(posedge clk) disable iff (rst)
        !(update_o && abort_o));
endmodule

bind sdac_wport sdac_wport_chk #(.CODE_W(CODE_W)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .code_o  (code_o),
    .mode_o  (mode_o),
    .update_o(update_o),
    .abort_o (abort_o)
);

// File: tb/sdac_wport_tb.sv
module sdac_wport_tb;
    localparam int HALF = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic sclk = 1'b1, frame_n = 1'b1, sdi = 1'b0;
    logic [11:0] code;
    logic [1:0]  mode;
    logic        pd, upd, abt;

    int n_vec = 0, n_bad = 0, n_upd = 0, n_abt = 0;
    logic [11:0] exp_code = '0;
    logic [1:0]  exp_mode = '0;

    always #10 clk = ~clk;

    sdac_wport u_dut (
        .clk(clk), .rst(rst), .sclk_i(sclk), .frame_n_i(frame_n), .sdi_i(sdi),
        .code_o(code), .mode_o(mode), .powered_down_o(pd),
        .update_o(upd), .abort_o(abt)
    );

    always @(posedge clk) begin
        if (!rst) begin
            if (upd) n_upd++;
            if (abt) n_abt++;
        end
    end

    task automatic wclk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_vec++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s got=%0h exp=%0h", tag, got, exp);
        end
    endtask

    task automatic send(input logic [15:0] w, input int nbits, input int extra, input bit coincide);
        frame_n = 1'b0;
        wclk(HALF);
        for (int i = 0; i < nbits; i++) begin
            sdi = w[15-i];
            wclk(HALF);
            sclk = 1'b0;
            if (coincide && i == nbits - 1) frame_n = 1'b1;
            wclk(HALF);
            sclk = 1'b1;
        end
        for (int j = 0; j < extra; j++) begin
            sdi = ~sdi;
            wclk(HALF);
            sclk = 1'b0;
            wclk(HALF);
            sclk = 1'b1;
        end
        wclk(HALF);
        frame_n = 1'b1;
        wclk(10);
    endtask

    task automatic frame(input string tag, input logic [15:0] w, input int nbits,
                         input int extra, input bit coincide);
        int u0, a0;
        u0 = n_upd;
        a0 = n_abt;
        send(w, nbits, extra, coincide);
        if (nbits == 16) begin
            exp_code = w[11:0];
            exp_mode = w[13:12];
        end
        chk({tag, " code"}, code, exp_code);
        chk({tag, " mode"}, mode, exp_mode);
        chk({tag, " pd"}, pd, exp_mode != 2'd0);
        chk({tag, " upd"}, n_upd - u0, (nbits == 16) ? 1 : 0);
        chk({tag, " abt"}, n_abt - a0, (nbits == 16) ? 0 : 1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        wclk(5);
        rst = 1'b0;
        wclk(5);
        // R1: reset state
        chk("R1 code", code, 0);
        chk("R1 mode", mode, 0);
        chk("R1 pd", pd, 0);
        chk("R1 pulses", n_upd + n_abt, 0);
        // R1: incomplete frame after reset leaves zero
        frame("R1 early", 16'hFFFF, 15, 0, 1'b0);

        // R2 R3 R4: sweep codes, all modes, varied pad bits
        for (int m = 0; m < 4; m++) begin
            for (int k = 0; k < 16; k++) begin
                logic [11:0] c;
                logic [1:0]  pad;
                c   = 12'((k * 273 + m * 37 + ((k == 15) ? 4095 : 0)) & 12'hFFF);
                pad = 2'(k);
                frame("R2R3 sweep", {pad, 2'(m), c}, 16, 0, 1'b0);
            end
        end

        // R4: pad bits ignored
        frame("R4 pad00", 16'h0A5A, 16, 0, 1'b0);
        frame("R4 pad11", 16'hCA5A, 16, 0, 1'b0);
        chk("R4 same code", code, 12'hA5A);

        // R5: abort after each possible count of edges
        frame("R5 base", 16'h0123, 16, 0, 1'b0);
        for (int n = 0; n < 16; n++) frame("R5 abort", 16'h3EDC, n, 0, 1'b0);

        // R6: extra edges after the sixteenth ignored
        frame("R6 extra", 16'h1456, 16, 5, 1'b0);
        // R6: edges with strobe high do nothing
        begin
            int u0;
            u0 = n_upd;
            for (int e = 0; e < 20; e++) begin
                sdi = e[0];
                wclk(HALF);
                sclk = 1'b0;
                wclk(HALF);
                sclk = 1'b1;
            end
            wclk(10);
            chk("R6 idle code", code, exp_code);
            chk("R6 idle mode", mode, exp_mode);
            chk("R6 idle upd", n_upd - u0, 0);
        end

        // R8: last edge and strobe rise coincide -> commit
        frame("R8 coincide", 16'h2BCD, 16, 0, 1'b1);

        // R9: power-down frame loads its code
        frame("R9 pd float", 16'h3ABC, 16, 0, 1'b0);
        chk("R9 code kept", code, 12'hABC);
        frame("R9 wake", 16'h0777, 16, 0, 1'b0);

        // R7: pulses counted against frames
        frame("R7 final", 16'h1001, 16, 0, 1'b0);

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule